// File: doc/BRIEF.md
# PLL Frequency-to-Counter Calculator

This block turns a requested output clock frequency, given as an unsigned integer in hertz, into the counter settings that a fractional-N PLL needs when its reference is a fixed 100 MHz clock. A single-cycle start strobe latches the request. The block then runs three exact integer divisions in sequence on one shared restoring divider. The first picks the post-divider count. The second takes the integer part of the feedback multiplier. The third takes its 24-bit fractional part. No floating point is used at any step.

The result comes back with a one-cycle valid pulse. It holds the post-divider count, the VCO halving enable and the reference-divider bypass flag, which depend on the band. It also holds the integer multiplier split into a high half, a low half and an odd flag, and the fraction. A request outside the supported band is answered with a valid pulse that carries an error flag, and the settings from before stay as they were. Writing these values into a PLL reconfiguration port belongs to the surrounding logic.

Top module: `pllc_freq_calc`

## Requirements
- R1: A start with freq_hz below 1,000,000 or above 600,000,000 produces a valid pulse with res_error = 1, and every setting output keeps its previous value.
- R2: For 1,000,000 <= freq_hz <= 50,000,000 the result has c_count = floor(200,000,000 / f), vco_div2 = 1, n_bypass = 0 and VCO = 4 * f * c_count.
- R3: For 50,000,000 < freq_hz <= 600,000,000 the result has c_count = floor(600,000,000 / f), vco_div2 = 0, n_bypass = 1 and VCO = 2 * f * c_count.
- R4: The integer multiplier m_high + m_low equals floor(VCO / 100,000,000).
- R5: When that integer multiplier M is odd, m_high = (M >> 1) + 1, m_low = M >> 1 and m_odd = 1.
- R6: When M is even, m_high = m_low = M >> 1 and m_odd = 0.
- R7: m_frac equals floor(((VCO mod 100,000,000) * 2^24) / 100,000,000).
- R8: res_valid is high for exactly one cycle for each accepted or rejected start, and res_error is high only together with res_valid.
- R9: A start raised while a computation is in progress is ignored. It produces no extra result, and the result in progress is not altered.
- R10: After reset, res_valid, res_error and all setting outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, sampled while idle |
| freq_hz | input | 32 | Requested output frequency in Hz |
| res_valid | output | 1 | One-cycle result strobe |
| res_error | output | 1 | Request was out of range (with res_valid) |
| c_count | output | 8 | Output post-divider count |
| vco_div2 | output | 1 | VCO divide-by-2 enable |
| n_bypass | output | 1 | Reference divider bypass |
| m_high | output | 8 | Feedback multiplier high half |
| m_low | output | 8 | Feedback multiplier low half |
| m_odd | output | 1 | Feedback multiplier is odd |
| m_frac | output | 24 | Feedback multiplier fraction, scaled by 2^24 |

## Verification
A wrong divider step or a lost remainder shows up as a wrong c_count, a wrong multiplier split or a wrong m_frac on the very next valid pulse, about 170 cycles after start. A stuck sequencer shows up as a missing valid pulse, which the bench catches by timeout. A valid pulse that is too long, or a start that leaks in while busy, shows up as a second result at the ports. Random frequencies that cross the 50 MHz band edge and the 600 MHz limit drive the band and range logic into both of its states.

// File: rtl/pllc_pkg.sv
package pllc_pkg;
  localparam int unsigned FREQ_W  = 32;
  localparam int unsigned CNT_W   = 8;
  localparam int unsigned FRAC_W  = 24;
  localparam int unsigned DIV_W   = FREQ_W + FRAC_W;

  localparam logic [FREQ_W-1:0] REF_HZ      = 32'd100_000_000;
  localparam logic [FREQ_W-1:0] MIN_HZ      = 32'd1_000_000;
  localparam logic [FREQ_W-1:0] MAX_HZ      = 32'd600_000_000;
  localparam logic [FREQ_W-1:0] LOW_MAX_HZ  = 32'd50_000_000;
  localparam logic [FREQ_W-1:0] LOW_NUM_HZ  = 32'd200_000_000;
  localparam logic [FREQ_W-1:0] HIGH_NUM_HZ = 32'd600_000_000;

  typedef enum logic [1:0] {ST_IDLE, ST_CDIV, ST_MDIV, ST_KDIV} calc_state_e;

  typedef struct packed {
    logic [CNT_W-1:0] hi;
    logic [CNT_W-1:0] lo;
    logic             odd;
  } mult_split_t;

  function automatic mult_split_t split_mult(input logic [CNT_W-1:0] m);
    mult_split_t s;
    s.lo  = m >> 1;
    s.odd = m[0];
    s.hi  = s.lo + {{(CNT_W-1){1'b0}}, m[0]};
    return s;
  endfunction

  function automatic logic [DIV_W-1:0] vco_of(input logic [FREQ_W-1:0] f,
                                              input logic [CNT_W-1:0] c,
                                              input logic low);
    logic [DIV_W-1:0] p;
    p = DIV_W'(f) * DIV_W'(c);
    return low ? (p << 2) : (p << 1);
  endfunction
endpackage

// File: rtl/pllc_divider.sv
module pllc_divider #(
  parameter int unsigned W = 56
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);
  localparam int unsigned CW = $clog2(W);

  logic [W-1:0]  dvs_q;
  logic [CW-1:0] cnt_q;
  logic [W:0]    trial;
  logic          fits;
  logic [W-1:0]  rem_nx;

  always_comb begin
    trial  = {remainder, quotient[W-1]};
    fits   = trial >= {1'b0, dvs_q};
    rem_nx = fits ? W'(trial - {1'b0, dvs_q}) : trial[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
      dvs_q     <= '0;
      cnt_q     <= '0;
    end else begin
      done <= 1'b0;
      if (go) begin
        busy      <= 1'b1;
        quotient  <= dividend;
        remainder <= '0;
        dvs_q     <= divisor;
        cnt_q     <= '0;
      end else if (busy) begin
        remainder <= rem_nx;
        quotient  <= {quotient[W-2:0], fits};
        cnt_q     <= cnt_q + 1'b1;
        if (cnt_q == CW'(W-1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pllc_band_sel.sv
module pllc_band_sel
  import pllc_pkg::*;
(
  input  logic [FREQ_W-1:0] freq,
  output logic              in_range,
  output logic              low_band,
  output logic [FREQ_W-1:0] numer
);
  always_comb begin
    in_range = (freq >= MIN_HZ) && (freq <= MAX_HZ);
    low_band = freq <= LOW_MAX_HZ;
    numer    = low_band ? LOW_NUM_HZ : HIGH_NUM_HZ;
  end
endmodule

// File: rtl/pllc_mult_split.sv
module pllc_mult_split
  import pllc_pkg::*;
(
  input  logic [CNT_W-1:0] m_int,
  output mult_split_t      split
);
  always_comb split = split_mult(m_int);
endmodule

// File: rtl/pllc_freq_calc.sv
module pllc_freq_calc
  import pllc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [FREQ_W-1:0] freq_hz,
  output logic              res_valid,
  output logic              res_error,
  output logic [CNT_W-1:0]  c_count,
  output logic              vco_div2,
  output logic              n_bypass,
  output logic [CNT_W-1:0]  m_high,
  output logic [CNT_W-1:0]  m_low,
  output logic              m_odd,
  output logic [FRAC_W-1:0] m_frac
);
  calc_state_e       state_q;
  logic [FREQ_W-1:0] freq_q;
  logic              low_q;
  logic [CNT_W-1:0]  c_q;
  logic [CNT_W-1:0]  mint_q;

  logic              in_range, low_band;
  logic [FREQ_W-1:0] numer;
  mult_split_t       split;

  logic              div_go, div_busy, div_done;
  logic [DIV_W-1:0]  div_a, div_b, div_quo, div_rem;
  logic              calc_busy;

  assign calc_busy = state_q != ST_IDLE;

  pllc_band_sel u_band (
    .freq     (freq_hz),
    .in_range (in_range),
    .low_band (low_band),
    .numer    (numer)
  );

  pllc_mult_split u_split (
    .m_int (mint_q),
    .split (split)
  );

  pllc_divider #(.W(DIV_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (div_go),
    .dividend  (div_a),
    .divisor   (div_b),
    .busy      (div_busy),
    .done      (div_done),
    .quotient  (div_quo),
    .remainder (div_rem)
  );

  always_comb begin
    div_go = 1'b0;
    div_a  = '0;
    div_b  = '0;
    unique case (state_q)
      ST_IDLE: if (start && in_range) begin
        div_go = 1'b1;
        div_a  = DIV_W'(numer);
        div_b  = DIV_W'(freq_hz);
      end
      ST_CDIV: if (div_done) begin
        div_go = 1'b1;
        div_a  = vco_of(freq_q, div_quo[CNT_W-1:0], low_q);
        div_b  = DIV_W'(REF_HZ);
      end
      ST_MDIV: if (div_done) begin
        div_go = 1'b1;
        div_a  = div_rem << FRAC_W;
        div_b  = DIV_W'(REF_HZ);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      freq_q    <= '0;
      low_q     <= 1'b0;
      c_q       <= '0;
      mint_q    <= '0;
      res_valid <= 1'b0;
      res_error <= 1'b0;
      c_count   <= '0;
      vco_div2  <= 1'b0;
      n_bypass  <= 1'b0;
      m_high    <= '0;
      m_low     <= '0;
      m_odd     <= 1'b0;
      m_frac    <= '0;
    end else begin
      res_valid <= 1'b0;
      res_error <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start) begin
          if (in_range) begin
            freq_q  <= freq_hz;
            low_q   <= low_band;
            state_q <= ST_CDIV;
          end else begin
            res_valid <= 1'b1;
            res_error <= 1'b1;
          end
        end
        ST_CDIV: if (div_done) begin
          c_q     <= div_quo[CNT_W-1:0];
          state_q <= ST_MDIV;
        end
        ST_MDIV: if (div_done) begin
          mint_q  <= div_quo[CNT_W-1:0];
          state_q <= ST_KDIV;
        end
        ST_KDIV: if (div_done) begin
          c_count   <= c_q;
          vco_div2  <= low_q;
          n_bypass  <= !low_q;
          m_high    <= split.hi;
          m_low     <= split.lo;
          m_odd     <= split.odd;
          m_frac    <= div_quo[FRAC_W-1:0];
          res_valid <= 1'b1;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pllc_freq_calc_chk.sv
module pllc_freq_calc_chk
  import pllc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              res_valid,
  input logic              res_error,
  input logic [CNT_W-1:0]  c_count,
  input logic              vco_div2,
  input logic              n_bypass,
  input logic [CNT_W-1:0]  m_high,
  input logic [CNT_W-1:0]  m_low,
  input logic              m_odd,
  input logic [FRAC_W-1:0] m_frac,
  input logic              calc_busy,
  input logic              div_go,
  input logic              div_busy,
  input logic [FREQ_W-1:0] freq_q
);
  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  p_err_needs_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_error |-> res_valid);

  p_hold_on_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_error) |-> ($stable(c_count) && $stable(m_high) &&
      $stable(m_low) && $stable(m_frac) && $stable(m_odd)));

  p_band_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_error) |-> (vco_div2 != n_bypass));

  p_c_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_error) |-> (c_count != '0));

  p_odd_split_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_error && m_odd) |-> (m_high == m_low + 1'b1));

  p_even_split_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_error && !m_odd) |-> (m_high == m_low));

  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    div_go |-> !div_busy);

  p_req_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (calc_busy && $past(calc_busy) && start) |=> $stable(freq_q));
endmodule

bind pllc_freq_calc pllc_freq_calc_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .res_valid (res_valid),
  .res_error (res_error),
  .c_count   (c_count),
  .vco_div2  (vco_div2),
  .n_bypass  (n_bypass),
  .m_high    (m_high),
  .m_low     (m_low),
  .m_odd     (m_odd),
  .m_frac    (m_frac),
  .calc_busy (calc_busy),
  .div_go    (div_go),
  .div_busy  (div_busy),
  .freq_q    (freq_q)
);

// File: tb/pllc_freq_calc_test.sv
module pllc_freq_calc_test;
  localparam int CLK_PERIOD = 10;
  localparam int RESULT_WAIT = 400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] freq_hz = '0;
  logic        res_valid, res_error, vco_div2, n_bypass, m_odd;
  logic [7:0]  c_count, m_high, m_low;
  logic [23:0] m_frac;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pllc_freq_calc uut (
    .clk(clk), .rst_n(rst_n), .start(start), .freq_hz(freq_hz),
    .res_valid(res_valid), .res_error(res_error), .c_count(c_count),
    .vco_div2(vco_div2), .n_bypass(n_bypass), .m_high(m_high),
    .m_low(m_low), .m_odd(m_odd), .m_frac(m_frac)
  );

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit model_ok(input longint f);
    return (f >= 64'd1_000_000) && (f <= 64'd600_000_000);
  endfunction

  task automatic model(input longint f, output longint c, output longint d2,
                       output longint mi, output longint fr);
    longint vco, r;
    if (f <= 64'd50_000_000) begin
      c = 64'd200_000_000 / f; vco = c * f * 4; d2 = 1;
    end else begin
      c = 64'd600_000_000 / f; vco = c * f * 2; d2 = 0;
    end
    mi = vco / 64'd100_000_000;
    r  = vco - mi * 64'd100_000_000;
    fr = (r * 64'd16777216) / 64'd100_000_000;
  endtask

  task automatic pulse_start(input logic [31:0] f);
    @(negedge clk);
    freq_hz = f;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_valid(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < RESULT_WAIT; i++) begin
      if (res_valid) begin seen = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic run_one(input logic [31:0] f);
    bit seen;
    longint c, d2, mi, fr;
    longint pc, ph, pl, pf;
    pc = c_count; ph = m_high; pl = m_low; pf = m_frac;
    if (res_valid) @(negedge clk);
    pulse_start(f);
    wait_valid(seen);
    check("R8", "valid seen", seen, 1);
    if (!seen) return;
    if (!model_ok(f)) begin
      check("R1", "error flag", res_error, 1);
      check("R1", "c held", c_count, pc);
      check("R1", "m_high held", m_high, ph);
      check("R1", "m_low held", m_low, pl);
      check("R1", "m_frac held", m_frac, pf);
    end else begin
      model(f, c, d2, mi, fr);
      check("R8", "no error", res_error, 0);
      if (d2 == 1) begin
        check("R2", "c_count low band", c_count, c);
        check("R2", "div2 low band", vco_div2, 1);
        check("R2", "bypass low band", n_bypass, 0);
      end else begin
        check("R3", "c_count high band", c_count, c);
        check("R3", "div2 high band", vco_div2, 0);
        check("R3", "bypass high band", n_bypass, 1);
      end
      check("R4", "m sum", m_high + m_low, mi);
      if (mi % 2 == 1) begin
        check("R5", "odd hi", m_high, mi / 2 + 1);
        check("R5", "odd lo", m_low, mi / 2);
        check("R5", "odd flag", m_odd, 1);
      end else begin
        check("R6", "even hi", m_high, mi / 2);
        check("R6", "even lo", m_low, mi / 2);
        check("R6", "even flag", m_odd, 0);
      end
      check("R7", "fraction", m_frac, fr);
    end
    @(negedge clk);
    check("R8", "valid one cycle", res_valid, 0);
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit seen;
    logic [31:0] f;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", "valid after reset", res_valid, 0);
    check("R10", "error after reset", res_error, 0);
    check("R10", "c after reset", c_count, 0);
    check("R10", "m_high after reset", m_high, 0);
    check("R10", "m_low after reset", m_low, 0);
    check("R10", "frac after reset", m_frac, 0);
    check("R10", "flags after reset", {vco_div2, n_bypass, m_odd}, 0);

    run_one(32'd1_000_000);
    run_one(32'd50_000_000);
    run_one(32'd50_000_001);
    run_one(32'd600_000_000);
    run_one(32'd33_333_333);
    run_one(32'd156_250_000);
    run_one(32'd999_999);
    run_one(32'd600_000_001);
    run_one(32'd0);
    run_one(32'hFFFF_FFFF);
    run_one(32'd7_000_000);
    run_one(32'd75_000_000);

    // R9: second start during a computation must be ignored
    pulse_start(32'd3_000_000);
    repeat (10) @(negedge clk);
    freq_hz = 32'd599_000_000;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_valid(seen);
    check("R9", "first result seen", seen, 1);
    check("R9", "c from first request", c_count, 66);
    check("R9", "div2 from first request", vco_div2, 1);
    @(negedge clk);
    wait_valid(seen);
    check("R9", "no second result", seen, 0);

    for (int n = 0; n < 150; n++) begin
      f = 32'd1_000_000 + ($urandom % 32'd601_000_000);
      if (n % 10 == 0) f = $urandom % 32'd1_000_000;
      run_one(f);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule